// File: doc/BRIEF.md
# Move-format instruction decoder

This block is the purely combinational decode stage of a small 8-bit register-transfer processor. Every instruction is a single move: a source field names where a value comes from, a destination field names which register captures it, and two flag bits request a memory write and a program-counter step. The decoder turns one 16-bit instruction word into a shared source selector for all destination registers, one load enable per destination, a memory write strobe, a program-counter step strobe and the 8-bit immediate value.

Two debug controls are layered on top of the normal path. A bypass input makes the decoder read its word from a debug scan register instead of the instruction register, so a host can inject single instructions. A squelch input silences every state-changing output while the debug path rewrites the instruction register, so nothing in the datapath moves during that window. The selector and immediate keep following the chosen word in both cases.

Top module: `move_decoder`

## Requirements
- R1: `src_sel` equals bits 15:13 of the chosen word, unchanged. Code meaning for the datapath: 0..3 pick R0..R3, 4 the destination's own value, 5 the immediate, 6 the adder sum (for R0) or memory read data (for R1..R3 and the PC), 7 the destination's debug copy.
- R2: `imm_data` always equals bits 7:0 of the chosen word, regardless of squelch.
- R3: Without squelch, destination field (bits 12:10) values 0..3 assert exactly `gpr_load[value]` and leave `pc_load` low.
- R4: Without squelch, destination value 4 asserts `pc_load` and no `gpr_load` bit.
- R5: Destination values 5..7 assert no load enable; at no time is more than one of `gpr_load` and `pc_load` high.
- R6: Without squelch, `mem_write` equals bit 9 and `pc_step` equals bit 8 of the chosen word, for every destination value.
- R7: With `bypass_en` high the chosen word is `scan_word`; with it low the chosen word is `instr_word`.
- R8: With `squelch_en` high, `gpr_load`, `pc_load`, `mem_write` and `pc_step` are all 0, with or without bypass.
- R9: The all-zero word decodes as a no-op move of R0 into itself: `src_sel`=0, `gpr_load`=4'b0001, `pc_load`, `mem_write`, `pc_step` all 0, `imm_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 16 | Word held in the instruction register |
| scan_word | input | 16 | Word held in the debug scan register |
| bypass_en | input | 1 | Decode `scan_word` instead of `instr_word` |
| squelch_en | input | 1 | Force all state-changing outputs low |
| src_sel | output | 3 | Shared source selector for all destinations |
| gpr_load | output | 4 | Load enables for R0..R3 (bit n = Rn) |
| pc_load | output | 1 | Program-counter load enable |
| mem_write | output | 1 | Main-memory write strobe |
| pc_step | output | 1 | Program-counter increment enable |
| imm_data | output | 8 | Immediate field of the chosen word |

## Verification
The bench builds the decoder with its default parameters: 3-bit source and destination fields, four general registers and an 8-bit immediate. With those values every combination of source code, destination code and the two flag bits is only 256 words, so the bench walks all of them with a varying immediate and compares each output against an independent model. Separate scenarios pit differing instruction and scan words against each other to show which one is decoded, and combine squelch with bypass to show that the strobes stay low while selector and immediate keep tracking.

// File: rtl/mvdec_pkg.sv
package mvdec_pkg;

  // Meaning of a source code as seen by a destination register.
  typedef enum logic [2:0] {
    SRC_REG0   = 3'd0,
    SRC_REG1   = 3'd1,
    SRC_REG2   = 3'd2,
    SRC_REG3   = 3'd3,
    SRC_SELF   = 3'd4,
    SRC_IMM    = 3'd5,
    SRC_ALT    = 3'd6,
    SRC_SHADOW = 3'd7
  } src_code_e;

  // Total instruction width: source, destination, two flags, immediate.
  function automatic int unsigned word_width(input int unsigned src_w,
                                             input int unsigned dst_w,
                                             input int unsigned imm_w);
    return src_w + dst_w + 2 + imm_w;
  endfunction

  // Bit position of the program-counter step flag.
  function automatic int unsigned step_pos(input int unsigned imm_w);
    return imm_w;
  endfunction

  // Bit position of the memory write flag.
  function automatic int unsigned write_pos(input int unsigned imm_w);
    return imm_w + 1;
  endfunction

  // Lowest bit of the destination field.
  function automatic int unsigned dst_lsb(input int unsigned imm_w);
    return imm_w + 2;
  endfunction

  // Lowest bit of the source field.
  function automatic int unsigned src_lsb(input int unsigned imm_w,
                                          input int unsigned dst_w);
    return imm_w + 2 + dst_w;
  endfunction

endpackage

// File: rtl/mvdec_word_pick.sv
module mvdec_word_pick #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] ir_word,
  input  logic [WORD_W-1:0] dbg_word,
  input  logic              use_dbg,
  output logic [WORD_W-1:0] chosen
);
  always_comb begin
    if (use_dbg) chosen = dbg_word;
    else         chosen = ir_word;
  end
endmodule

// File: rtl/mvdec_field_split.sv
module mvdec_field_split
  import mvdec_pkg::*;
#(
  parameter int SRC_W = 3,
  parameter int DST_W = 3,
  parameter int IMM_W = 8,
  localparam int WORD_W = int'(word_width(SRC_W, DST_W, IMM_W))
) (
  input  logic [WORD_W-1:0] word,
  output logic [SRC_W-1:0]  src_f,
  output logic [DST_W-1:0]  dst_f,
  output logic              wr_f,
  output logic              step_f,
  output logic [IMM_W-1:0]  imm_f
);
  localparam int SRC_LO  = int'(src_lsb(IMM_W, DST_W));
  localparam int DST_LO  = int'(dst_lsb(IMM_W));
  localparam int WR_BIT  = int'(write_pos(IMM_W));
  localparam int STP_BIT = int'(step_pos(IMM_W));

  assign src_f  = word[SRC_LO +: SRC_W];
  assign dst_f  = word[DST_LO +: DST_W];
  assign wr_f   = word[WR_BIT];
  assign step_f = word[STP_BIT];
  assign imm_f  = word[IMM_W-1:0];
endmodule

// File: rtl/mvdec_dst_decode.sv
module mvdec_dst_decode #(
  parameter int DST_W   = 3,
  parameter int NUM_GPR = 4,
  localparam int NUM_LD = NUM_GPR + 1
) (
  input  logic [DST_W-1:0]  dst_f,
  output logic [NUM_LD-1:0] load_vec
);
  // Index NUM_GPR is the program counter; higher codes hit nothing.
  for (genvar i = 0; i < NUM_LD; i++) begin : g_hit
    assign load_vec[i] = (dst_f == DST_W'(i));
  end
endmodule

// File: rtl/mvdec_quiet_gate.sv
module mvdec_quiet_gate #(
  parameter int NUM_LD = 5
) (
  input  logic              quiet,
  input  logic [NUM_LD-1:0] load_in,
  input  logic              wr_in,
  input  logic              step_in,
  output logic [NUM_LD-1:0] load_out,
  output logic              wr_out,
  output logic              step_out
);
  assign load_out = quiet ? '0 : load_in;
  assign wr_out   = wr_in   & ~quiet;
  assign step_out = step_in & ~quiet;
endmodule

// File: rtl/move_decoder.sv
module move_decoder
  import mvdec_pkg::*;
#(
  parameter int SRC_W   = 3,
  parameter int DST_W   = 3,
  parameter int IMM_W   = 8,
  parameter int NUM_GPR = 4,
  localparam int WORD_W = int'(word_width(SRC_W, DST_W, IMM_W))
) (
  input  logic [WORD_W-1:0]  instr_word,
  input  logic [WORD_W-1:0]  scan_word,
  input  logic               bypass_en,
  input  logic               squelch_en,
  output logic [SRC_W-1:0]   src_sel,
  output logic [NUM_GPR-1:0] gpr_load,
  output logic               pc_load,
  output logic               mem_write,
  output logic               pc_step,
  output logic [IMM_W-1:0]   imm_data
);
  localparam int NUM_LD = NUM_GPR + 1;

  // Named internal events, visible to the bound checker.
  logic [WORD_W-1:0] picked_word;
  logic [DST_W-1:0]  dst_field;
  logic              wr_field;
  logic              step_field;
  logic [NUM_LD-1:0] raw_loads;
  logic [NUM_LD-1:0] gated_loads;

  mvdec_word_pick #(.WORD_W(WORD_W)) u_pick (
    .ir_word  (instr_word),
    .dbg_word (scan_word),
    .use_dbg  (bypass_en),
    .chosen   (picked_word)
  );

  mvdec_field_split #(.SRC_W(SRC_W), .DST_W(DST_W), .IMM_W(IMM_W)) u_split (
    .word   (picked_word),
    .src_f  (src_sel),
    .dst_f  (dst_field),
    .wr_f   (wr_field),
    .step_f (step_field),
    .imm_f  (imm_data)
  );

  mvdec_dst_decode #(.DST_W(DST_W), .NUM_GPR(NUM_GPR)) u_dst (
    .dst_f    (dst_field),
    .load_vec (raw_loads)
  );

  mvdec_quiet_gate #(.NUM_LD(NUM_LD)) u_gate (
    .quiet    (squelch_en),
    .load_in  (raw_loads),
    .wr_in    (wr_field),
    .step_in  (step_field),
    .load_out (gated_loads),
    .wr_out   (mem_write),
    .step_out (pc_step)
  );

  assign gpr_load = gated_loads[NUM_GPR-1:0];
  assign pc_load  = gated_loads[NUM_GPR];
endmodule

// File: rtl/move_decoder_chk.sv
module move_decoder_chk #(
  parameter int SRC_W   = 3,
  parameter int DST_W   = 3,
  parameter int IMM_W   = 8,
  parameter int NUM_GPR = 4,
  localparam int WORD_W = SRC_W + DST_W + 2 + IMM_W
) (
  input logic [WORD_W-1:0]  instr_word,
  input logic [WORD_W-1:0]  scan_word,
  input logic               bypass_en,
  input logic               squelch_en,
  input logic [SRC_W-1:0]   src_sel,
  input logic [NUM_GPR-1:0] gpr_load,
  input logic               pc_load,
  input logic               mem_write,
  input logic               pc_step,
  input logic [IMM_W-1:0]   imm_data,
  input logic [WORD_W-1:0]  picked_word
);
  localparam int DST_LO = IMM_W + 2;
  localparam int SRC_LO = IMM_W + 2 + DST_W;

  logic [WORD_W-1:0] port_word;
  logic [DST_W-1:0]  port_dst;
  assign port_word = bypass_en ? scan_word : instr_word;
  assign port_dst  = port_word[DST_LO +: DST_W];

  always_comb begin
    // R7 / R1: selector follows the word chosen by the bypass input
    p_word_route_r7: assert (src_sel == port_word[SRC_LO +: SRC_W]);
    // R2: immediate tracks the chosen word even under squelch
    p_imm_track_r2: assert (imm_data == picked_word[IMM_W-1:0]);
    // R5: never two load enables at once
    p_onehot_loads_r5: assert ($onehot0({pc_load, gpr_load}));
    // R8: squelch silences every strobe
    if (squelch_en)
      p_squelch_quiet_r8: assert (gpr_load == '0 && !pc_load && !mem_write && !pc_step);
    if (!squelch_en) begin
      // R6: flags pass through
      p_ctrl_bits_r6: assert (mem_write == port_word[IMM_W+1] && pc_step == port_word[IMM_W]);
      // R3: general register destination
      if (int'(port_dst) < NUM_GPR)
        p_gpr_hit_r3: assert (gpr_load == NUM_GPR'(1 << port_dst) && !pc_load);
      // R4: program-counter destination
      if (int'(port_dst) == NUM_GPR)
        p_pc_hit_r4: assert (pc_load && gpr_load == '0);
      // R5: unused destinations load nothing
      if (int'(port_dst) > NUM_GPR)
        p_no_load_r5: assert (!pc_load && gpr_load == '0);
    end
  end
endmodule

bind move_decoder move_decoder_chk #(
  .SRC_W(SRC_W), .DST_W(DST_W), .IMM_W(IMM_W), .NUM_GPR(NUM_GPR)
) u_chk (
  .instr_word  (instr_word),
  .scan_word   (scan_word),
  .bypass_en   (bypass_en),
  .squelch_en  (squelch_en),
  .src_sel     (src_sel),
  .gpr_load    (gpr_load),
  .pc_load     (pc_load),
  .mem_write   (mem_write),
  .pc_step     (pc_step),
  .imm_data    (imm_data),
  .picked_word (picked_word)
);

// File: tb/move_decoder_tb_top.sv
module move_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] instr_word, scan_word;
  logic        bypass_en, squelch_en;
  logic [2:0]  src_sel;
  logic [3:0]  gpr_load;
  logic        pc_load, mem_write, pc_step;
  logic [7:0]  imm_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  move_decoder dut_i (
    .instr_word (instr_word),
    .scan_word  (scan_word),
    .bypass_en  (bypass_en),
    .squelch_en (squelch_en),
    .src_sel    (src_sel),
    .gpr_load   (gpr_load),
    .pc_load    (pc_load),
    .mem_write  (mem_write),
    .pc_step    (pc_step),
    .imm_data   (imm_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive just after a rising edge, sample at the falling edge.
  task automatic apply(input logic [15:0] iw, input logic [15:0] sw,
                       input logic byp, input logic sq);
    @(posedge clk);
    #1;
    instr_word = iw; scan_word = sw; bypass_en = byp; squelch_en = sq;
    @(negedge clk);
  endtask

  // Independent model of the decode, written from the requirements.
  task automatic expect_word(input logic [15:0] w, input logic sq, input string ctx);
    int dst;
    int exp_gpr;
    int exp_pc;
    dst = (w >> 10) & 7;
    exp_gpr = 0;
    exp_pc  = 0;
    if (!sq) begin
      if (dst <= 3) exp_gpr = 1 << dst;
      else if (dst == 4) exp_pc = 1;
    end
    check({"R1 src_sel ", ctx}, int'(src_sel), (w >> 13) & 7);
    check({"R2 imm_data ", ctx}, int'(imm_data), w & 8'hFF);
    if (dst <= 3)
      check({"R3 gpr_load ", ctx}, int'(gpr_load), exp_gpr);
    else
      check({"R5 gpr_load ", ctx}, int'(gpr_load), exp_gpr);
    if (dst == 4)
      check({"R4 pc_load ", ctx}, int'(pc_load), exp_pc);
    else
      check({"R5 pc_load ", ctx}, int'(pc_load), exp_pc);
    check({"R6 mem_write ", ctx}, int'(mem_write), sq ? 0 : ((w >> 9) & 1));
    check({"R6 pc_step ", ctx}, int'(pc_step), sq ? 0 : ((w >> 8) & 1));
  endtask

  task automatic t_zero_word();
    apply(16'h0000, 16'hFFFF, 1'b0, 1'b0);
    check("R9 nop src_sel", int'(src_sel), 0);
    check("R9 nop gpr_load", int'(gpr_load), 4'b0001);
    check("R9 nop pc_load", int'(pc_load), 0);
    check("R9 nop mem_write", int'(mem_write), 0);
    check("R9 nop pc_step", int'(pc_step), 0);
    check("R9 nop imm_data", int'(imm_data), 0);
  endtask

  task automatic t_full_sweep();
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++)
        for (int f = 0; f < 4; f++) begin
          logic [15:0] w;
          w = {3'(s), 3'(d), 2'(f), 8'((s * 37 + d * 11 + f * 5) ^ 8'hA5)};
          apply(w, ~w, 1'b0, 1'b0);
          expect_word(w, 1'b0, "sweep");
        end
  endtask

  task automatic t_bypass();
    logic [15:0] a, b;
    a = {3'd5, 3'd1, 2'b10, 8'h3C};
    b = {3'd6, 3'd4, 2'b01, 8'hC3};
    apply(a, b, 1'b1, 1'b0);
    expect_word(b, 1'b0, "R7 bypass picks scan");
    apply(a, b, 1'b0, 1'b0);
    expect_word(a, 1'b0, "R7 no bypass picks ir");
    apply(16'h0000, {3'd7, 3'd3, 2'b11, 8'h81}, 1'b1, 1'b0);
    check("R7 scan dst3 gpr_load", int'(gpr_load), 4'b1000);
    check("R7 scan src7", int'(src_sel), 7);
  endtask

  task automatic t_squelch();
    logic [15:0] w;
    for (int d = 0; d < 8; d++) begin
      w = {3'(d), 3'(d), 2'b11, 8'(d * 29 + 1)};
      apply(w, 16'h0000, 1'b0, 1'b1);
      expect_word(w, 1'b1, "R8 squelch ir");
      apply(16'h0000, w, 1'b1, 1'b1);
      expect_word(w, 1'b1, "R8 squelch bypass");
    end
    apply(16'h0000, 16'h0000, 1'b0, 1'b1);
    check("R8 squelched nop gpr_load", int'(gpr_load), 0);
  endtask

  initial begin
    instr_word = '0; scan_word = '0; bypass_en = 1'b0; squelch_en = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_zero_word();
    t_full_sweep();
    t_bypass();
    t_squelch();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule